// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiplier Core

This block multiplies two floating-point operands held in an unpacked working format. Each operand is a sign bit, a biased exponent one bit wider than the stored exponent, and a mantissa word. The mantissa word has the hidden bit at position FRAC_W+3 and the fraction just below it. Its three lowest positions are round, guard and sticky, and two spare positions sit above the hidden bit. The result comes back in the same format, rounded to nearest with ties to even, so the mantissa that comes out always has its three low bits clear.

A caller places both operands on the inputs and raises the chip select. The core captures the operands on the first clock edge. It builds the significand product over several cycles, one slice of the second significand per cycle, then spends one cycle on normalisation and one on rounding. After that it raises valid. The result and valid stay put for as long as the chip select stays high. Dropping the chip select clears valid on the next edge, and it also abandons any computation that has not finished. Subnormal operands and results are handled: inputs with a zero exponent carry a clear hidden bit and count as exponent 1, and results that fall below the normal range shift right into the subnormal range with sticky accumulation. With the default parameters (EXP_W=11, FRAC_W=52, CHUNK_W=18) the core is a double-precision unit with 58-bit mantissa words and 12-bit exponents.

Top module: `fmul_core`

## Requirements
- R1: Result mantissa words have round, guard and sticky (bits 2..0) at zero. The two bits above the hidden bit (positions FRAC_W+4 and FRAC_W+5) are also zero. The result exponent never exceeds 2^EXP_W-1.
- R2: The result sign is the exclusive OR of the two operand signs, and this holds for zero, subnormal and infinite results too.
- R3: An operand exponent of 0 marks a subnormal input. The core uses the input hidden bit at position FRAC_W+3 exactly as given, and treats that operand's exponent as 1.
- R4: For a normal result, the exponent is the sum of the effective operand exponents minus the bias 2^(EXP_W-1)-1, plus one when the significand product is at least 2. The hidden bit is set, and the fraction is rounded to nearest, with exact ties going to the even fraction.
- R5: A result below the normal range has exponent 0 and a clear hidden bit. It is rounded to nearest even at the subnormal scale. If rounding carries into the hidden bit, the result has exponent 1 and a set hidden bit.
- R6: A zero operand, or a product that rounds to nothing at the subnormal scale, gives exponent 0 with an all-zero mantissa and the sign from R2.
- R7: A rounded exponent of 2^EXP_W-1 or more gives infinity: exponent 2^EXP_W-1, hidden bit set, fraction zero.
- R8: Valid rises exactly ceil((FRAC_W+1)/CHUNK_W)+3 rising edges after the first edge that sees chip select high, counting that edge. Every significand slice is accumulated before valid rises.
- R9: While chip select stays high after valid, valid and all result outputs hold their values.
- R10: When chip select is low at an edge, valid is low after that edge. A computation abandoned this way never raises valid, and the next request computes correctly.
- R11: After reset, valid is low and the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Starts a multiplication and holds its result while high |
| opSignA | input | 1 | Sign of operand A |
| opExpA | input | EXP_W+1 | Biased exponent of operand A |
| opMantA | input | FRAC_W+6 | Mantissa word of operand A |
| opSignB | input | 1 | Sign of operand B |
| opExpB | input | EXP_W+1 | Biased exponent of operand B |
| opMantB | input | FRAC_W+6 | Mantissa word of operand B |
| resSign | output | 1 | Result sign |
| resExp | output | EXP_W+1 | Result biased exponent |
| resMant | output | FRAC_W+6 | Result mantissa word, round/guard/sticky clear |
| resValid | output | 1 | Result ready |

## Verification
The bench uses a 5-bit exponent and 6-bit fraction configuration. It sweeps every fraction pair at unit scale, which makes exact round-to-even ties appear often. A core that rounded ties away from zero would return an odd fraction one step too high, and a core that lost the sticky bits would round down values that sit just above a half step. Mixed subnormal and tiny-exponent sweeps target the gradual underflow path. A core that skipped the effective-exponent-1 rule for subnormal inputs would come out exactly one binade off, and one that lost the carry into the hidden bit would report exponent 0 for the smallest normal result. A full exponent-pair sweep reaches overflow, where a missing clamp would wrap the exponent. Separate sequences abandon a request midway and hold the chip select high after completion; a core that lets a stale computation finish would raise valid after the abort.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_NORM,
    ST_RND,
    ST_DONE
  } mulState_e;

  // strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic accum;  // fold one significand slice into the product
    logic norm;   // register normalised / denormalised mantissa
    logic round;  // register the rounded result
  } mulStrobe_t;

endpackage

// File: rtl/fmul_control.sv
module fmul_control
  import fmul_pkg::*;
#(
  parameter int N_CHUNK = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSel,
  output mulStrobe_t strobe,
  output logic       resValid
);

  localparam int CNT_W = $clog2(N_CHUNK + 1);

  mulState_e        stateQ, stateD;
  logic [CNT_W-1:0] stepQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (!chipSel) begin
      stateD = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          strobe.load = 1'b1;
          stateD      = ST_MUL;
        end
        ST_MUL: begin
          strobe.accum = 1'b1;
          if (stepQ == CNT_W'(N_CHUNK - 1)) stateD = ST_NORM;
        end
        ST_NORM: begin
          strobe.norm = 1'b1;
          stateD      = ST_RND;
        end
        ST_RND: begin
          strobe.round = 1'b1;
          stateD       = ST_DONE;
        end
        default: stateD = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)       stepQ <= '0;
      else if (strobe.accum) stepQ <= stepQ + CNT_W'(1);
    end
  end

  assign resValid = (stateQ == ST_DONE);

  // R8: every slice has been folded in when valid appears
  p_all_slices_r8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> (stepQ == CNT_W'(N_CHUNK)));

  // R8: valid only follows a cycle with chip select high
  p_rose_after_sel_r8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(chipSel));

  // R10: chip select low at an edge clears valid
  p_sel_low_clears_r10 : assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !resValid);

endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath
  import fmul_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int CHUNK_W = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  mulStrobe_t          strobe,
  input  logic                opSignA,
  input  logic [EXP_W:0]      opExpA,
  input  logic [FRAC_W+5:0]   opMantA,
  input  logic                opSignB,
  input  logic [EXP_W:0]      opExpB,
  input  logic [FRAC_W+5:0]   opMantB,
  output logic                resSign,
  output logic [EXP_W:0]      resExp,
  output logic [FRAC_W+5:0]   resMant
);

  localparam int EXPI_W  = EXP_W + 1;
  localparam int MANT_W  = FRAC_W + 6;
  localparam int HID     = FRAC_W + 3;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int N_CHUNK = (SIG_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W   = N_CHUNK * CHUNK_W;
  localparam int PP_W    = SIG_W + CHUNK_W;
  localparam int WIDE_W  = PROD_W + MANT_W;
  localparam int SE_W    = EXPI_W + 3;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int MAX_E   = (1 << EXP_W) - 1;

  logic                     signQ;
  logic [EXPI_W-1:0]        effExpA, effExpB;
  logic [SIG_W-1:0]         sigAQ;
  logic [PAD_W-1:0]         bPadQ;
  logic [PROD_W-1:0]        accQ;
  logic [MANT_W-1:0]        normMantQ, normMantD;
  logic signed [SE_W-1:0]   normExpQ, normExpD;
  logic [MANT_W-1:0]        rndMantD;
  logic [EXPI_W-1:0]        rndExpD;
  logic [CHUNK_W-1:0]       slice;
  logic [PP_W-1:0]          partial;

  logic unusedMantBits;
  assign unusedMantBits = ^{opMantA[MANT_W-1:HID+1], opMantA[2:0],
                            opMantB[MANT_W-1:HID+1], opMantB[2:0]};

  // most significant slice first: the running sum only ever shifts by a constant
  assign slice   = bPadQ[PAD_W-1 -: CHUNK_W];
  assign partial = PP_W'(sigAQ) * PP_W'(slice);

  // place the leading one at the hidden position, or denormalise below exponent 1
  always_comb begin
    int lead;
    int eSum;
    int sh;
    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] mask;
    logic sticky;
    lead = 0;
    for (int i = 0; i < PROD_W; i++) begin
      if (accQ[i]) lead = i;
    end
    eSum     = int'(effExpA) + int'(effExpB) - BIAS + lead - 2 * FRAC_W;
    normExpD = '0;
    sticky   = 1'b0;
    mask     = '0;
    wide     = WIDE_W'(accQ);
    if (eSum >= 1) begin
      sh       = lead - HID;
      normExpD = SE_W'(eSum);
    end else begin
      sh = lead - HID + 1 - eSum;
    end
    if (accQ == '0) begin
      wide     = '0;
      normExpD = '0;
    end else if (sh >= PROD_W) begin
      wide   = '0;
      sticky = 1'b1;
    end else if (sh > 0) begin
      mask   = (WIDE_W'(1) << sh) - WIDE_W'(1);
      sticky = |(wide & mask);
      wide   = wide >> sh;
    end else if (sh < 0) begin
      wide = wide << (-sh);
    end
    normMantD = wide[MANT_W-1:0] | MANT_W'(sticky);
  end

  // nearest-even rounding, carry renormalisation, overflow clamp
  always_comb begin
    logic                   up;
    logic [MANT_W-4:0]      kept;
    logic [MANT_W-1:0]      rm;
    logic signed [SE_W-1:0] e;
    up   = normMantQ[2] & (normMantQ[1] | normMantQ[0] | normMantQ[3]);
    kept = normMantQ[MANT_W-1:3] + (MANT_W-3)'(up);
    rm   = {kept, 3'b000};
    e    = normExpQ;
    if (rm[HID+1]) begin
      rm       = rm >> 1;
      rm[2:0]  = 3'b000;
      e        = e + SE_W'(1);
    end else if ((e == SE_W'(0)) && rm[HID]) begin
      e = SE_W'(1);
    end
    if (e >= SE_W'(MAX_E)) begin
      e       = SE_W'(MAX_E);
      rm      = '0;
      rm[HID] = 1'b1;
    end
    rndMantD = rm;
    rndExpD  = e[EXPI_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signQ     <= 1'b0;
      effExpA   <= '0;
      effExpB   <= '0;
      sigAQ     <= '0;
      bPadQ     <= '0;
      accQ      <= '0;
      normMantQ <= '0;
      normExpQ  <= '0;
      resSign   <= 1'b0;
      resExp    <= '0;
      resMant   <= '0;
    end else begin
      if (strobe.load) begin
        signQ   <= opSignA ^ opSignB;
        effExpA <= (opExpA == '0) ? EXPI_W'(1) : opExpA;
        effExpB <= (opExpB == '0) ? EXPI_W'(1) : opExpB;
        sigAQ   <= opMantA[HID:3];
        bPadQ   <= PAD_W'(opMantB[HID:3]);
        accQ    <= '0;
      end
      if (strobe.accum) begin
        accQ  <= (accQ << CHUNK_W) + PROD_W'(partial);
        bPadQ <= bPadQ << CHUNK_W;
      end
      if (strobe.norm) begin
        normMantQ <= normMantD;
        normExpQ  <= normExpD;
      end
      if (strobe.round) begin
        resSign <= signQ;
        resExp  <= rndExpD;
        resMant <= rndMantD;
      end
    end
  end

endmodule

// File: rtl/fmul_core.sv
module fmul_core
  import fmul_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int CHUNK_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              opSignA,
  input  logic [EXP_W:0]    opExpA,
  input  logic [FRAC_W+5:0] opMantA,
  input  logic              opSignB,
  input  logic [EXP_W:0]    opExpB,
  input  logic [FRAC_W+5:0] opMantB,
  output logic              resSign,
  output logic [EXP_W:0]    resExp,
  output logic [FRAC_W+5:0] resMant,
  output logic              resValid
);

  localparam int MANT_W  = FRAC_W + 6;
  localparam int HID     = FRAC_W + 3;
  localparam int EXPI_W  = EXP_W + 1;
  localparam int N_CHUNK = (FRAC_W + CHUNK_W) / CHUNK_W;
  localparam int MAX_E   = (1 << EXP_W) - 1;

  mulStrobe_t strobe;

  fmul_control #(.N_CHUNK(N_CHUNK)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .strobe   (strobe),
    .resValid (resValid)
  );

  fmul_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CHUNK_W(CHUNK_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opSignA (opSignA),
    .opExpA  (opExpA),
    .opMantA (opMantA),
    .opSignB (opSignB),
    .opExpB  (opExpB),
    .opMantB (opMantB),
    .resSign (resSign),
    .resExp  (resExp),
    .resMant (resMant)
  );

  p_grs_clear_r1 : assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resMant[2:0] == 3'b000) && (resMant[MANT_W-1:HID+1] == '0));

  p_exp_ceiling_r1 : assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resExp <= EXPI_W'(MAX_E)));

  p_sign_xor_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (resValid && chipSel) |-> (resSign == (opSignA ^ opSignB)));

  p_hidden_tracks_exp_r5 : assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((resExp == '0) == !resMant[HID]));

  p_inf_frac_zero_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resExp == EXPI_W'(MAX_E))) |-> (resMant[HID-1:3] == '0));

  p_hold_result_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (resValid && chipSel) |=> resValid && $stable(resSign) && $stable(resExp)
                              && $stable(resMant));

endmodule

// File: tb/sim_fmul_core.sv
module sim_fmul_core;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int T_EXP_W   = 5;
  localparam int T_FRAC_W  = 6;
  localparam int T_CHUNK_W = 3;
  localparam int T_EXPI_W  = T_EXP_W + 1;
  localparam int T_MANT_W  = T_FRAC_W + 6;
  localparam int T_HID     = T_FRAC_W + 3;
  localparam int T_BIAS    = (1 << (T_EXP_W - 1)) - 1;
  localparam int T_MAX_E   = (1 << T_EXP_W) - 1;
  localparam int T_SLICES  = (T_FRAC_W + T_CHUNK_W) / T_CHUNK_W;
  localparam int LAT       = T_SLICES + 3;
  localparam int WATCHDOG  = 190000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                chipSel = 1'b0;
  logic                opSignA = 1'b0, opSignB = 1'b0;
  logic [T_EXPI_W-1:0] opExpA = '0, opExpB = '0;
  logic [T_MANT_W-1:0] opMantA = '0, opMantB = '0;
  logic                resSign;
  logic [T_EXPI_W-1:0] resExp;
  logic [T_MANT_W-1:0] resMant;
  logic                resValid;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  fmul_core #(.EXP_W(T_EXP_W), .FRAC_W(T_FRAC_W), .CHUNK_W(T_CHUNK_W)) u0 (
    .clk(clk), .rstN(rstN), .chipSel(chipSel),
    .opSignA(opSignA), .opExpA(opExpA), .opMantA(opMantA),
    .opSignB(opSignB), .opExpB(opExpB), .opMantB(opMantB),
    .resSign(resSign), .resExp(resExp), .resMant(resMant), .resValid(resValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [T_MANT_W-1:0] mkMant(input int e, input int f);
    logic [T_MANT_W-1:0] m;
    m = T_MANT_W'(f) << 3;
    if (e != 0) m[T_HID] = 1'b1;
    return m;
  endfunction

  // arithmetic reference: exact product scaled to the target unit in the last place
  task automatic refMul(input int ea, input int fa, input int eb, input int fb,
                        output int eOut, output longint sigOut);
    longint sa, sb, p, quo, rem, half;
    int effA, effB, k, lg, eu, ulp, d;
    sa   = (ea == 0) ? longint'(fa) : longint'(fa + (1 << T_FRAC_W));
    sb   = (eb == 0) ? longint'(fb) : longint'(fb + (1 << T_FRAC_W));
    effA = (ea == 0) ? 1 : ea;
    effB = (eb == 0) ? 1 : eb;
    p    = sa * sb;
    if (p == 0) begin
      eOut = 0;
      sigOut = 0;
      return;
    end
    k  = effA + effB - 2 * T_BIAS - 2 * T_FRAC_W;
    lg = 0;
    for (int i = 0; i < 40; i++) if (p[i]) lg = i;
    eu  = lg + k + T_BIAS;
    ulp = (eu >= 1) ? (eu - T_BIAS - T_FRAC_W) : (1 - T_BIAS - T_FRAC_W);
    d   = ulp - k;
    if (d <= 0) begin
      quo = p << (-d);
    end else begin
      quo  = p >> d;
      rem  = p - (quo << d);
      half = longint'(1) << (d - 1);
      if (rem > half || (rem == half && quo[0])) quo++;
    end
    eOut = (eu >= 1) ? eu : 0;
    if (quo == (longint'(1) << (T_FRAC_W + 1))) begin
      quo = quo >> 1;
      eOut++;
    end else if (eOut == 0 && quo >= (longint'(1) << T_FRAC_W)) begin
      eOut = 1;
    end
    if (eOut >= T_MAX_E) begin
      eOut = T_MAX_E;
      quo  = longint'(1) << T_FRAC_W;
    end
    sigOut = quo;
  endtask

  task automatic driveOps(input logic sA, input int eA, input int fA,
                          input logic sB, input int eB, input int fB);
    opSignA = sA;
    opExpA  = T_EXPI_W'(eA);
    opMantA = mkMant(eA, fA);
    opSignB = sB;
    opExpB  = T_EXPI_W'(eB);
    opMantB = mkMant(eB, fB);
  endtask

  task automatic runOp(input logic sA, input int eA, input int fA,
                       input logic sB, input int eB, input int fB);
    int eExp, cyc;
    longint sigExp, expWord, actWord;
    string tag;
    refMul(eA, fA, eB, fB, eExp, sigExp);
    if (eExp == T_MAX_E)                 tag = "R7";
    else if (eExp == 0 && sigExp == 0)   tag = "R6";
    else if (eExp == 0)                  tag = "R5";
    else if (eA == 0 || eB == 0)         tag = "R3";
    else                                 tag = "R4";
    driveOps(sA, eA, fA, sB, eB, fB);
    chipSel = 1'b1;
    cyc = 0;
    while (!resValid && cyc < 4 * LAT) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == LAT, "R8", "latency", cyc, LAT);
    check(resSign == (sA ^ sB), "R2", "sign", resSign, sA ^ sB);
    check(resMant[2:0] == 3'b000 && resMant[T_MANT_W-1:T_HID+1] == '0, "R1",
          "mantissa spare bits", resMant, sigExp << 3);
    expWord = (longint'(eExp) << T_MANT_W) | (sigExp << 3);
    actWord = (longint'(resExp) << T_MANT_W) | longint'(resMant);
    if (actWord != expWord)
      $display("  operands e%0d f%0d x e%0d f%0d", eA, fA, eB, fB);
    check(actWord == expWord, tag, "exponent and mantissa", actWord, expWord);
    chipSel = 1'b0;
    @(negedge clk);
    check(!resValid, "R10", "valid after release", resValid, 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL R8 watchdog expired: actual %0d expected below %0d", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : stimulus
    logic                holdSign;
    logic [T_EXPI_W-1:0] holdExp;
    logic [T_MANT_W-1:0] holdMant;
    int fa2[3];
    int fb2[3];
    int eaList[4];
    int ebList[5];

    repeat (3) @(negedge clk);
    check(!resValid, "R11", "valid in reset", resValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!resValid && resMant == '0 && resExp == '0 && !resSign, "R11",
          "outputs after reset", resMant, 0);

    // unit-scale operands: every fraction pair, ties to even appear often
    for (int fa = 0; fa < 64; fa++)
      for (int fb = 0; fb < 64; fb++)
        runOp(fa[0], T_BIAS, fa, fb[1], T_BIAS, fb);

    // subnormal inputs and gradual underflow
    eaList = '{0, 1, 2, 3};
    ebList = '{0, 1, 4, 8, 12};
    foreach (eaList[i])
      foreach (ebList[j])
        for (int fa = 0; fa < 64; fa += 4)
          for (int fb = 1; fb < 64; fb += 6)
            runOp(fb[0], eaList[i], fa, fa[1], ebList[j], fb);

    // every exponent pair with a few fraction patterns, reaching overflow
    fa2 = '{0, 63, 21};
    fb2 = '{0, 63, 42};
    for (int ea = 0; ea < T_MAX_E; ea++)
      for (int eb = 0; eb < T_MAX_E; eb++)
        for (int q = 0; q < 3; q++)
          runOp(ea[0], ea, fa2[q], eb[1], eb, fb2[q]);

    // zero operand keeps a signed zero
    runOp(1'b1, 0, 0, 1'b0, 20, 5);

    // R9: hold chip select past completion
    driveOps(1'b1, 17, 45, 1'b1, 13, 9);
    chipSel = 1'b1;
    repeat (LAT) @(negedge clk);
    holdSign = resSign;
    holdExp  = resExp;
    holdMant = resMant;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(resValid && resSign == holdSign && resExp == holdExp && resMant == holdMant,
            "R9", "result held", resMant, holdMant);
    end
    chipSel = 1'b0;
    @(negedge clk);

    // R10: abandon a request midway, valid must stay low
    driveOps(1'b0, 16, 30, 1'b1, 14, 50);
    chipSel = 1'b1;
    repeat (2) @(negedge clk);
    chipSel = 1'b0;
    for (int c = 0; c < 2 * LAT; c++) begin
      @(negedge clk);
      check(!resValid, "R10", "valid after abort", resValid, 0);
    end
    runOp(1'b0, 16, 30, 1'b1, 14, 50);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule